// File: doc/BRIEF.md
# Memory-mapped BCD real-time clock

This block places a calendar clock inside a byte-wide static-memory address space. A host reaches it with a chip-enable, write-enable and output-enable bus carrying a 19-bit address and 8-bit data. The sixteen highest byte addresses open a small register bank. Its lowest seven bytes show the time in packed BCD: hundredths, seconds, minutes, hours, day of month, month and two-digit year. The other nine bytes are general-purpose bytes. Every address below that window reaches ordinary storage.

Timekeeping runs in a private counter chain that advances on a 100 Hz tick enable. Once per second, on the tick where hundredths wrap, the new counter values are copied into the visible clock registers. Host accesses go on during that copy without any wait. When the host writes a clock register, the matching counter is loaded directly. A power-fail input makes the block ignore chip enable while it is high, so no read or write reaches memory, registers or counters.

Top module: `bcd_rtc_sram`

## Requirements
- R1: An address whose upper 15 bits are all ones selects register offset `addr[3:0]`. Any other address selects storage entry `addr[STORE_AW-1:0]`, so storage repeats every 2**STORE_AW bytes below the window.
- R2: A cycle with `bus_ce`=1, `bus_we`=1 and `bus_pfail`=0 writes `bus_wdata` at the rising edge. A later read of the same location returns that byte.
- R3: `bus_rvalid` is 1 only when `bus_ce`=1, `bus_oe`=1, `bus_we`=0 and `bus_pfail`=0. In that case `bus_rdata` gives the addressed byte in the same cycle. Otherwise `bus_rvalid`=0 and `bus_rdata`=00h.
- R4: Register offsets 0..6 hold hundredths, seconds, minutes, hours, date, month and year in packed BCD. On a carry these roll over at 99, 59, 59, 23, end of month, 12 and 99. They return to 00, except date and month, which return to 01. A field that has not reached its limit steps by one in BCD.
- R5: The last day of the month is 29 for month 02 in a year whose value is divisible by 4, and 28 for month 02 in any other year. It is 30 for months 04, 06, 09 and 11, and 31 for all other months.
- R6: Offsets 0..6 change only in two cases: a host write, or the tick on which hundredths wrap. On that tick all seven take the counters' new values.
- R7: A host write to offset 0..6 loads both the counter and the visible register, and counting continues from that value. If the write falls on a tick or a refresh, the written value wins for that field. Carries into higher fields still come from the values before the write.
- R8: Offsets 7..15 are plain read/write bytes that a refresh never alters.
- R9: While `bus_pfail`=1, no read is answered and nothing is written to storage, registers or counters. Ticks still advance the time.
- R10: After reset, offsets 0..6 read 00 00 00 00 01 01 00, and offsets 7..15 read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle enable at 100 Hz that advances the time |
| bus_pfail | input | 1 | Power fail: blocks every access while high |
| bus_ce | input | 1 | Chip enable, active high |
| bus_we | input | 1 | Write enable, active high |
| bus_oe | input | 1 | Output enable, active high |
| bus_addr | input | 19 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 00h when not valid |
| bus_rvalid | output | 1 | Read data is driven |

## Verification
The host write to a clock register and the once-per-second refresh can land in the same clock cycle. The bench provokes this by loading hundredths with 99 and then raising the tick in the very cycle it writes seconds, and in another run hundredths itself. It judges the outcome by reading all seven clock registers at once and again a full second later. The bench model predicts both reads: the written field holds the host value, and every other field carries the refresh. A power-fail window also overlaps a refresh, so the bench can check that time keeps moving while host writes are dropped.

// File: rtl/rtcm_pkg.sv
package rtcm_pkg;
   localparam int unsigned NFIELD    = 7;
   localparam int unsigned IDX_DATE  = 4;
   localparam int unsigned IDX_MONTH = 5;
   localparam int unsigned IDX_YEAR  = 6;

   typedef logic [7:0] bcd8_t;

   // packed BCD byte to binary
   function automatic logic [7:0] bcd_to_bin(input bcd8_t v);
      return ({4'h0, v[7:4]} * 8'd10) + {4'h0, v[3:0]};
   endfunction

   function automatic logic year_is_leap(input bcd8_t yr);
      logic [7:0] b;
      b = bcd_to_bin(yr);
      return (b[1:0] == 2'b00);
   endfunction

   function automatic bcd8_t month_end(input bcd8_t mon, input bcd8_t yr);
      case (mon)
         8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic bcd8_t field_limit(input int idx, input bcd8_t mon, input bcd8_t yr);
      case (idx)
         0:       return 8'h99;
         1, 2:    return 8'h59;
         3:       return 8'h23;
         4:       return month_end(mon, yr);
         5:       return 8'h12;
         default: return 8'h99;
      endcase
   endfunction

   function automatic bcd8_t field_floor(input int idx);
      return (idx == 4 || idx == 5) ? 8'h01 : 8'h00;
   endfunction

   function automatic bcd8_t bcd_step(input bcd8_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
      return v + 8'd1;
   endfunction
endpackage

// File: rtl/rtcm_bcd_field.sv
module rtcm_bcd_field
   import rtcm_pkg::*;
#(
   parameter bcd8_t FLOOR = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  inc_i,
   input  bcd8_t limit_i,
   input  logic  load_i,
   input  bcd8_t load_val_i,
   output bcd8_t value_o,
   output bcd8_t next_o,
   output logic  wrap_o
);
   bcd8_t value_q;

   assign wrap_o  = inc_i && (value_q >= limit_i);
   assign value_o = value_q;

   always_comb begin
      if (load_i)      next_o = load_val_i;
      else if (wrap_o) next_o = FLOOR;
      else if (inc_i)  next_o = bcd_step(value_q);
      else             next_o = value_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) value_q <= FLOOR;
      else        value_q <= next_o;
   end

   // R4: a field at or past its limit returns to its floor value
   a_r4_wrap_to_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && value_q >= limit_i) |=> value_q == FLOOR);

   // R4: a field below its limit with a low digit under 9 steps by one
   a_r4_step_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && value_q < limit_i && value_q[3:0] < 4'd9)
      |=> value_q == $past(value_q) + 8'd1);

   // R7: a host load overrides any tick in the same cycle
   a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> value_q == $past(load_val_i));
endmodule

// File: rtl/rtcm_time_chain.sv
module rtcm_time_chain
   import rtcm_pkg::*;
#(
   parameter int unsigned NF = NFIELD
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic [NF-1:0]        load_mask_i,
   input  bcd8_t                load_val_i,
   output logic [NF-1:0][7:0]   next_o,
   output logic                 sec_wrap_o
);
   logic [NF:0]          carry;
   logic [NF-1:0][7:0]   cnt;

   generate
      if (NF != 7) begin : g_bad_nf
         $error("rtcm_time_chain: exactly seven calendar fields are supported");
      end
   endgenerate

   assign carry[0] = tick_i;

   generate
      for (genvar g = 0; g < NF; g++) begin : g_field
         localparam bcd8_t FL = field_floor(g);
         bcd8_t lim;
         assign lim = field_limit(g, cnt[IDX_MONTH], cnt[IDX_YEAR]);
         rtcm_bcd_field #(.FLOOR(FL)) i_field (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_i      (carry[g]),
            .limit_i    (lim),
            .load_i     (load_mask_i[g]),
            .load_val_i (load_val_i),
            .value_o    (cnt[g]),
            .next_o     (next_o[g]),
            .wrap_o     (carry[g+1])
         );
      end
   endgenerate

   assign sec_wrap_o = carry[1];

   // R5: the day of month never runs past the month end unless the host wrote it
   a_r5_date_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (carry[IDX_DATE] && !load_mask_i[IDX_DATE] && !load_mask_i[IDX_MONTH]
       && !load_mask_i[IDX_YEAR] && cnt[IDX_DATE] <= month_end(cnt[IDX_MONTH], cnt[IDX_YEAR]))
      |=> cnt[IDX_DATE] <= 8'h31);
endmodule

// File: rtl/rtcm_regbank.sv
module rtcm_regbank
   import rtcm_pkg::*;
#(
   parameter int unsigned OFF_W = 4,
   parameter int unsigned NF    = NFIELD,
   localparam int unsigned NREG = 1 << OFF_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [OFF_W-1:0]       wr_off_i,
   input  bcd8_t                  wr_data_i,
   input  logic                   refresh_i,
   input  logic [NF-1:0][7:0]     fresh_i,
   output logic [NREG-1:0][7:0]   regs_o
);
   generate
      if (NF >= NREG) begin : g_bad_size
         $error("rtcm_regbank: clock fields must fit below the register count");
      end
   endgenerate

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         logic hit;
         assign hit = wr_en_i && (wr_off_i == OFF_W'(r));
         if (r < NF) begin : g_clock
            always_ff @(posedge clk) begin
               if (!rst_n)         regs_o[r] <= field_floor(r);
               else if (hit)       regs_o[r] <= wr_data_i;
               else if (refresh_i) regs_o[r] <= fresh_i[r];
            end
         end else begin : g_plain
            always_ff @(posedge clk) begin
               if (!rst_n)   regs_o[r] <= 8'h00;
               else if (hit) regs_o[r] <= wr_data_i;
            end
         end
      end
   endgenerate

   // R6: without a write or a refresh the whole bank holds
   a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (!refresh_i && !wr_en_i) |=> $stable(regs_o));

   // R8: a refresh leaves the plain bytes alone
   a_r8_plain_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_i && !wr_en_i) |=> $stable(regs_o[NREG-1:NF]));
endmodule

// File: rtl/rtcm_store.sv
module rtcm_store #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 8,
   localparam int unsigned DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);
   logic [DW-1:0] mem [DEPTH];

   generate
      if (AW > 16) begin : g_bad_aw
         $error("rtcm_store: storage depth exceeds the modelled limit");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we_i) mem[addr_i] <= wdata_i;
   end

   assign rdata_o = mem[addr_i];

   // R2: a write lands at the addressed entry
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> mem[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/bcd_rtc_sram.sv
module bcd_rtc_sram
   import rtcm_pkg::*;
#(
   parameter int unsigned ADDR_W    = 19,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned REG_OFF_W = 4,
   parameter int unsigned STORE_AW  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_100hz,
   input  logic              bus_pfail,
   input  logic              bus_ce,
   input  logic              bus_we,
   input  logic              bus_oe,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid
);
   localparam int unsigned NREG = 1 << REG_OFF_W;

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("bcd_rtc_sram: data path must be one byte");
      end
      if (STORE_AW >= ADDR_W) begin : g_bad_saw
         $error("bcd_rtc_sram: storage index must be narrower than the address");
      end
      if (REG_OFF_W >= ADDR_W) begin : g_bad_off
         $error("bcd_rtc_sram: register window wider than the address");
      end
   endgenerate

   logic                       is_reg;
   logic [REG_OFF_W-1:0]       off;
   logic                       access;
   logic                       reg_wr;
   logic                       mem_wr;
   logic [NFIELD-1:0]          load_mask;
   logic [NFIELD-1:0][7:0]     fresh;
   logic                       sec_wrap;
   logic [NREG-1:0][7:0]       regs;
   logic [DATA_W-1:0]          store_q;

   assign is_reg = &bus_addr[ADDR_W-1:REG_OFF_W];
   assign off    = bus_addr[REG_OFF_W-1:0];
   assign access = bus_ce && !bus_pfail;
   assign reg_wr = access && bus_we && is_reg;
   assign mem_wr = access && bus_we && !is_reg;

   generate
      for (genvar k = 0; k < NFIELD; k++) begin : g_load
         assign load_mask[k] = reg_wr && (off == REG_OFF_W'(k));
      end
   endgenerate

   rtcm_time_chain #(.NF(NFIELD)) i_chain (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_100hz),
      .load_mask_i (load_mask),
      .load_val_i  (bus_wdata),
      .next_o      (fresh),
      .sec_wrap_o  (sec_wrap)
   );

   rtcm_regbank #(.OFF_W(REG_OFF_W), .NF(NFIELD)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (reg_wr),
      .wr_off_i  (off),
      .wr_data_i (bus_wdata),
      .refresh_i (sec_wrap),
      .fresh_i   (fresh),
      .regs_o    (regs)
   );

   rtcm_store #(.AW(STORE_AW), .DW(DATA_W)) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_wr),
      .addr_i  (bus_addr[STORE_AW-1:0]),
      .wdata_i (bus_wdata),
      .rdata_o (store_q)
   );

   always_comb begin
      bus_rvalid = access && bus_oe && !bus_we;
      bus_rdata  = '0;
      if (bus_rvalid) bus_rdata = is_reg ? regs[off] : store_q;
   end

   // R9: during power fail the register bank changes only through the refresh
   a_r9_pfail_freezes_regs: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_pfail && !sec_wrap) |=> $stable(regs));
endmodule

// File: tb/test_bcd_rtc_sram.sv
module test_bcd_rtc_sram;
   localparam logic [18:0] RB = 19'h7FFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, pf = 1'b0, ce = 1'b0, we = 1'b0, oe = 1'b0;
   logic [18:0] addr = '0;
   logic [7:0]  wd = '0;
   logic [7:0]  rd;
   logic        rv;

   always #2 clk = ~clk;

   bcd_rtc_sram i_bcd_rtc_sram (
      .clk(clk), .rst_n(rst_n), .tick_100hz(tick), .bus_pfail(pf),
      .bus_ce(ce), .bus_we(we), .bus_oe(oe), .bus_addr(addr),
      .bus_wdata(wd), .bus_rdata(rd), .bus_rvalid(rv)
   );

   int n_vec = 0, n_bad = 0, n_cyc = 0;

   logic [6:0][7:0]  m_cnt;
   logic [15:0][7:0] m_vis;
   logic [7:0]       m_mem [1024];

   function automatic int b_bin(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] b_limit(input int k, input logic [7:0] mo, input logic [7:0] yr);
      if (k == 0 || k == 6) return 8'h99;
      if (k == 1 || k == 2) return 8'h59;
      if (k == 3) return 8'h23;
      if (k == 5) return 8'h12;
      if (mo == 8'h02) return (b_bin(yr) % 4 == 0) ? 8'h29 : 8'h28;
      if (mo == 8'h04 || mo == 8'h06 || mo == 8'h09 || mo == 8'h11) return 8'h30;
      return 8'h31;
   endfunction

   function automatic logic [7:0] b_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
      return v + 8'd1;
   endfunction

   task automatic model_edge(input bit c, w, p, t, input logic [18:0] a, input logic [7:0] d);
      logic [6:0][7:0] nx;
      bit carry, wrapped, wr, isreg;
      nx = m_cnt; carry = t; wrapped = 0;
      for (int k = 0; k < 7; k++) begin
         if (carry) begin
            if (m_cnt[k] >= b_limit(k, m_cnt[5], m_cnt[6])) begin
               nx[k] = (k == 4 || k == 5) ? 8'h01 : 8'h00;
               if (k == 0) wrapped = 1;
            end else begin
               nx[k] = b_inc(m_cnt[k]);
               carry = 0;
            end
         end
      end
      wr = c && w && !p;
      isreg = (a[18:4] == 15'h7FFF);
      if (wr && isreg && a[3:0] < 4'd7) nx[a[2:0]] = d;
      if (wrapped) for (int k = 0; k < 7; k++) m_vis[k] = nx[k];
      if (wr && isreg) m_vis[a[3:0]] = d;
      if (wr && !isreg) m_mem[a[9:0]] = d;
      m_cnt = nx;
   endtask

   task automatic cyc(input bit c, w, o, p, t, input logic [18:0] a, input logic [7:0] d, input string req);
      bit ev;
      logic [7:0] ed;
      ce = c; we = w; oe = o; pf = p; tick = t; addr = a; wd = d;
      #1;
      ev = c && o && !w && !p;
      ed = 8'h00;
      if (ev) ed = (a[18:4] == 15'h7FFF) ? m_vis[a[3:0]] : m_mem[a[9:0]];
      n_vec++;
      if (rv !== ev || rd !== ed) begin
         n_bad++;
         $display("FAIL %s addr=%h actual rvalid=%b data=%h expected rvalid=%b data=%h",
                  req, a, rv, rd, ev, ed);
      end
      @(posedge clk);
      model_edge(c, w, p, t, a, d);
      @(negedge clk);
   endtask

   task automatic wr(input logic [18:0] a, input logic [7:0] d, input string req);
      cyc(1, 1, 0, 0, 0, a, d, req);
   endtask

   task automatic rdc(input logic [18:0] a, input string req);
      cyc(1, 0, 1, 0, 0, a, 8'h00, req);
   endtask

   task automatic set_time(input logic [6:0][7:0] tv);
      for (int k = 0; k < 7; k++) wr(RB + 19'(k), tv[k], "R7");
   endtask

   task automatic read_clock(input string req);
      for (int k = 0; k < 7; k++) rdc(RB + 19'(k), req);
   endtask

   task automatic ticks(input int n, input int off, input string req);
      for (int i = 0; i < n; i++) cyc(1, 0, 1, 0, 1, RB + 19'(off), 8'h00, req);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog R1..: actual cycles=%0d expected below 150000", n_cyc);
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      m_cnt = '0; m_cnt[4] = 8'h01; m_cnt[5] = 8'h01;
      m_vis = '0; m_vis[4] = 8'h01; m_vis[5] = 8'h01;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: state after reset
      for (int k = 0; k < 16; k++) rdc(RB + 19'(k), "R10");

      // R2: fill storage, then R1 mirrored reads
      for (int i = 0; i < 1024; i++) wr(19'(i), 8'($urandom), "R2");
      for (int i = 0; i < 300; i++) rdc(19'($urandom_range(0, 32'h7FFEF)), "R1");

      // R3: read qualifiers
      cyc(1, 0, 0, 0, 0, 19'h00123, 8'h00, "R3");
      cyc(0, 0, 1, 0, 0, 19'h00123, 8'h00, "R3");
      cyc(1, 1, 1, 0, 0, 19'h00123, 8'h5A, "R3");
      rdc(19'h00123, "R2");
      rdc(19'h40123, "R1");

      // R4: year boundary
      set_time({8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h98});
      ticks(2, 6, "R4");
      read_clock("R4");

      // R5: leap and plain February, thirty-day month
      set_time({8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h99});
      ticks(1, 4, "R5");
      read_clock("R5");
      set_time({8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h99});
      ticks(1, 4, "R5");
      read_clock("R5");
      set_time({8'h07, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59, 8'h99});
      ticks(1, 5, "R5");
      read_clock("R5");

      // R6: cadence, visible time holds for 99 ticks then refreshes
      set_time({8'h10, 8'h06, 8'h15, 8'h08, 8'h30, 8'h20, 8'h00});
      ticks(99, 1, "R6");
      ticks(1, 1, "R6");
      read_clock("R6");

      // R7: host write collides with the refresh
      set_time({8'h10, 8'h06, 8'h15, 8'h08, 8'h30, 8'h20, 8'h99});
      cyc(1, 1, 0, 0, 1, RB + 19'd1, 8'h42, "R7");
      read_clock("R7");
      ticks(100, 0, "R7");
      read_clock("R7");
      set_time({8'h10, 8'h06, 8'h15, 8'h08, 8'h30, 8'h20, 8'h99});
      cyc(1, 1, 0, 0, 1, RB, 8'h37, "R7");
      read_clock("R7");

      // R8: plain bytes survive refreshes
      for (int k = 7; k < 16; k++) wr(RB + 19'(k), 8'($urandom), "R8");
      ticks(250, 2, "R8");
      for (int k = 7; k < 16; k++) rdc(RB + 19'(k), "R8");

      // R9: power fail blocks writes and reads, time keeps running
      set_time({8'h05, 8'h03, 8'h10, 8'h11, 8'h12, 8'h13, 8'h97});
      cyc(1, 1, 0, 1, 1, 19'h00077, 8'hEE, "R9");
      cyc(1, 1, 0, 1, 1, RB + 19'd9, 8'hEE, "R9");
      cyc(1, 1, 0, 1, 1, RB + 19'd2, 8'h44, "R9");
      cyc(1, 0, 1, 1, 1, RB + 19'd1, 8'h00, "R9");
      cyc(1, 0, 1, 1, 0, 19'h00077, 8'h00, "R9");
      rdc(19'h00077, "R9");
      rdc(RB + 19'd9, "R9");
      read_clock("R9");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         bit c, w, o, p, t;
         logic [18:0] a;
         c = ($urandom_range(0, 9) != 0);
         w = ($urandom_range(0, 2) == 0);
         o = ($urandom_range(0, 4) != 0);
         p = ($urandom_range(0, 9) == 0);
         t = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 1) == 0)
            a = RB + 19'(w ? $urandom_range(7, 15) : $urandom_range(0, 15));
         else
            a = 19'($urandom_range(0, 32'h7FFEF));
         cyc(c, w, o, p, t, a, 8'($urandom), "R3");
      end
      read_clock("R6");

      summary();
      $finish;
   end
endmodule